// File: doc/BRIEF.md
# Coherent Bus Arbiter

This block shares one external bus between the on-chip processor and a single external master. The external master asks for the bus with a request line. The arbiter answers with a grant, and the master confirms that it has taken the bus with a grant-acknowledge. The external request has the higher priority. The processor has the lowest priority and owns the bus whenever nobody else holds it.

The processor reports its own state to the arbiter on four lines:
- a transfer-in-progress line, high while a bus cycle runs;
- a last-cycle flag, high on the final bus cycle of an operand;
- a lock flag, high for the whole of an indivisible read-modify-write sequence;
- a boundary flag, high when the processor is between operands.

The arbiter raises the grant only at a point where releasing the bus cannot split an operand or a locked sequence. Inside a multi-operand operation, such as a register block move or exception stacking, the bus may change hands between operands.

The grant is also shaped in time. It stays low for a minimum number of clocks before it rises again. It falls a fixed number of clocks after the acknowledge is seen. The request input comes from outside the clock domain and passes through a synchronizer before it is used.

Top module: `coh_bus_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after its release with no request, busGrant is 0 and cpuOwnsBus is 1.
- R2: extReq passes through SYNC_STAGES flops. Take the processor idle at a boundary: cpuBusy=0, cpuBoundary=1, cpuLocked=0. Let extReq rise just after rising edge c. Then busGrant is 1 and cpuOwnsBus is 0 from edge c+SYNC_STAGES+1 onward, and busGrant is still 0 after edge c+SYNC_STAGES.
- R3: The grant never rises at an edge that samples the first or a middle cycle of an operand (cpuBusy=1, cpuLastCycle=0). It also never rises at the edge that samples the last cycle of a multi-cycle operand. This holds even with cpuBoundary=1. The grant may rise from the next edge on.
- R4: The grant never rises at an edge that samples cpuLocked=1.
- R5: The grant never rises at an edge that samples cpuBoundary=0. A pending request is granted at the first edge that samples an idle cycle with cpuBoundary=1 between two operands.
- R6: Once busGrant falls, it stays 0 for at least MIN_LOW (2) cycles, even if a request is pending again at once.
- R7: busGrant falls at the ACK_DELAY-th (2nd) rising edge, counting the first edge that samples extAck=1 while granted. busGrant and cpuOwnsBus are both 0 from then on.
- R8: Once the grant has fallen after an acknowledge, cpuOwnsBus stays 0 for as long as extAck is sampled 1. cpuOwnsBus returns to 1 at the first edge that samples extAck=0. busGrant and cpuOwnsBus are never 1 together.
- R9: If the synchronized request is seen low while granted and before any acknowledge, busGrant falls at that edge and cpuOwnsBus returns to 1 at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extReq | input | 1 | Bus request from the external master, asynchronous, active high |
| extAck | input | 1 | Grant-acknowledge from the external master, synchronous, active high |
| cpuBusy | input | 1 | Processor bus cycle in progress |
| cpuLastCycle | input | 1 | Current processor bus cycle is the last of its operand |
| cpuLocked | input | 1 | Indivisible read-modify-write sequence active |
| cpuBoundary | input | 1 | Processor sits between operands |
| busGrant | output | 1 | Bus grant to the external master, active high |
| cpuOwnsBus | output | 1 | Processor may run bus cycles |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_LOW=2 and ACK_DELAY=2. With these values every grant edge falls on a cycle that can be counted by hand. A request withdrawn for a single clock makes the minimum low time the only thing that holds the grant down, so a design without that counter is caught. A two-operand sequence and a four-cycle operand with the boundary flag held high show that operand tracking, not the boundary flag alone, blocks the grant. A short and a long acknowledge hold show that the processor returns exactly one edge after the acknowledge drops.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_CPU     = 2'd0,
    ST_GRANT   = 2'd1,
    ST_ACKWAIT = 2'd2,
    ST_EXT     = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grantSet;
    logic grantClr;
    logic ackLoad;
    logic ackStep;
  } arbStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic reqSeen;
    logic safePoint;
    logic lowOk;
    logic ackDone;
  } arbStatus_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2,
  parameter int ACK_DELAY   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extReq,
  input  logic       cpuBusy,
  input  logic       cpuLastCycle,
  input  logic       cpuLocked,
  input  logic       cpuBoundary,
  input  arbStrobe_t strobe,
  output arbStatus_t status,
  output logic       busGrant
);

  localparam int LOW_W = $clog2(MIN_LOW + 1);
  localparam int ACK_W = $clog2(ACK_DELAY + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [LOW_W-1:0]       lowCnt;
  logic [ACK_W-1:0]       ackCnt;
  logic                   inOperand;

  // request synchronizer, oldest stage at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], extReq};
  end

  // operand tracking: set after a non-final cycle, cleared by a final one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        inOperand <= 1'b0;
    else if (cpuBusy) inOperand <= !cpuLastCycle;
  end

  // grant register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busGrant <= 1'b0;
    else if (strobe.grantSet) busGrant <= 1'b1;
    else if (strobe.grantClr) busGrant <= 1'b0;
  end

  // cycles spent with the grant low, saturating at MIN_LOW
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= LOW_W'(MIN_LOW);
    else if (strobe.grantSet) lowCnt <= '0;
    else if (strobe.grantClr) lowCnt <= LOW_W'(1);
    else if (!busGrant && (lowCnt < LOW_W'(MIN_LOW)))
                              lowCnt <= lowCnt + LOW_W'(1);
  end

  // acknowledge-to-release delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ackCnt <= '0;
    else if (strobe.ackLoad) ackCnt <= ACK_W'(1);
    else if (strobe.ackStep) ackCnt <= ackCnt + ACK_W'(1);
  end

  always_comb begin
    status.reqSeen   = syncReg[SYNC_STAGES-1];
    status.safePoint = !cpuLocked && cpuBoundary && !inOperand &&
                       !(cpuBusy && !cpuLastCycle);
    status.lowOk     = (lowCnt >= LOW_W'(MIN_LOW));
    status.ackDone   = (ackCnt >= ACK_W'(ACK_DELAY - 1));
  end

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extAck,
  input  arbStatus_t status,
  output arbStrobe_t strobe,
  output logic       cpuOwnsBus
);

  arbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CPU;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_CPU: begin
        if (status.reqSeen && status.safePoint && status.lowOk) begin
          stateNext       = ST_GRANT;
          strobe.grantSet = 1'b1;
        end
      end
      ST_GRANT: begin
        if (extAck) begin
          stateNext      = ST_ACKWAIT;
          strobe.ackLoad = 1'b1;
        end else if (!status.reqSeen) begin
          stateNext       = ST_CPU;
          strobe.grantClr = 1'b1;
        end
      end
      ST_ACKWAIT: begin
        if (status.ackDone) begin
          stateNext       = ST_EXT;
          strobe.grantClr = 1'b1;
        end else begin
          strobe.ackStep = 1'b1;
        end
      end
      ST_EXT: begin
        if (!extAck) stateNext = ST_CPU;
      end
      default: stateNext = ST_CPU;
    endcase
  end

  assign cpuOwnsBus = (state == ST_CPU);

endmodule

// File: rtl/coh_bus_arbiter.sv
module coh_bus_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2,
  parameter int ACK_DELAY   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extReq,
  input  logic extAck,
  input  logic cpuBusy,
  input  logic cpuLastCycle,
  input  logic cpuLocked,
  input  logic cpuBoundary,
  output logic busGrant,
  output logic cpuOwnsBus
);

  arbStrobe_t strobe;
  arbStatus_t status;

  arb_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_LOW),
    .ACK_DELAY  (ACK_DELAY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .extReq      (extReq),
    .cpuBusy     (cpuBusy),
    .cpuLastCycle(cpuLastCycle),
    .cpuLocked   (cpuLocked),
    .cpuBoundary (cpuBoundary),
    .strobe      (strobe),
    .status      (status),
    .busGrant    (busGrant)
  );

  arb_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .extAck    (extAck),
    .status    (status),
    .strobe    (strobe),
    .cpuOwnsBus(cpuOwnsBus)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk,
  input logic rstN,
  input logic extReq,
  input logic extAck,
  input logic cpuBusy,
  input logic cpuLastCycle,
  input logic cpuLocked,
  input logic busGrant,
  input logic cpuOwnsBus
);

  // R2: a rising grant needs a request three edges earlier (2 sync flops + decision)
  p_req_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(extReq, 3));

  // R3: no grant out of the first or a middle cycle of an operand
  p_mid_operand_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBusy && !cpuLastCycle && !busGrant) |=> !busGrant);

  // R4: no grant while locked
  p_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuLocked && !busGrant) |=> !busGrant);

  // R6: low for at least two cycles
  p_min_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGrant) |=> !busGrant);

  // R8: exclusive ownership
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> !cpuOwnsBus);

  // R8: external master keeps the bus while acknowledging
  p_ext_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busGrant && !cpuOwnsBus && extAck) |=> !cpuOwnsBus);

  // R8: processor regains the bus one edge after acknowledge drops
  p_cpu_return_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busGrant && !cpuOwnsBus && !extAck) |=> cpuOwnsBus);

endmodule

bind coh_bus_arbiter arb_checker u_arbChecker (
  .clk         (clk),
  .rstN        (rstN),
  .extReq      (extReq),
  .extAck      (extAck),
  .cpuBusy     (cpuBusy),
  .cpuLastCycle(cpuLastCycle),
  .cpuLocked   (cpuLocked),
  .busGrant    (busGrant),
  .cpuOwnsBus  (cpuOwnsBus)
);

// File: tb/test_coh_bus_arbiter.sv
module test_coh_bus_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extReq = 1'b0, extAck = 1'b0;
  logic cpuBusy = 1'b0, cpuLastCycle = 1'b0, cpuLocked = 1'b0, cpuBoundary = 1'b1;
  logic busGrant, cpuOwnsBus;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    logic  g;
    logic  o;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coh_bus_arbiter #(.SYNC_STAGES(2), .MIN_LOW(2), .ACK_DELAY(2)) i_coh_bus_arbiter (
    .clk(clk), .rstN(rstN), .extReq(extReq), .extAck(extAck),
    .cpuBusy(cpuBusy), .cpuLastCycle(cpuLastCycle), .cpuLocked(cpuLocked),
    .cpuBoundary(cpuBoundary), .busGrant(busGrant), .cpuOwnsBus(cpuOwnsBus)
  );

  // monitor: compare queued expectations in their cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      exp_t item;
      item = expQ.pop_front();
      checks++;
      if (item.cyc != cyc || busGrant !== item.g || cpuOwnsBus !== item.o) begin
        errors++;
        $display("FAIL %s cycle %0d (due %0d): grant=%b own=%b expected grant=%b own=%b",
                 item.tag, cyc, item.cyc, busGrant, cpuOwnsBus, item.g, item.o);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectAt(int d, logic g, logic o, string tag);
    exp_t item;
    item.cyc = cyc + d;
    item.g   = g;
    item.o   = o;
    item.tag = tag;
    expQ.push_back(item);
  endtask

  // acknowledge the grant, hold it holdCyc cycles, then drop it
  task automatic releaseBus(int holdCyc);
    extAck = 1'b1;
    extReq = 1'b0;
    expectAt(1, 1'b1, 1'b0, "R7 grant held after ack");
    expectAt(2, 1'b0, 1'b0, "R7 grant falls after ack");
    expectAt(holdCyc, 1'b0, 1'b0, "R8 external keeps bus");
    repeat (holdCyc) step();
    extAck = 1'b0;
    expectAt(1, 1'b0, 1'b1, "R8 processor returns");
    repeat (4) step();
  endtask

  initial begin
    repeat (3) step();
    expectAt(0, 1'b0, 1'b1, "R1 in reset");
    step();
    rstN = 1'b1;
    expectAt(1, 1'b0, 1'b1, "R1 after reset");
    repeat (3) step();

    // R2 / R7 / R8: plain request from idle
    extReq = 1'b1;
    expectAt(2, 1'b0, 1'b1, "R2 not yet granted");
    expectAt(3, 1'b1, 1'b0, "R2 granted");
    repeat (4) step();
    releaseBus(4);

    // R3: four-cycle operand, boundary flag left high throughout
    cpuBusy = 1'b1; cpuLastCycle = 1'b0; extReq = 1'b1;
    expectAt(2, 1'b0, 1'b1, "R3 mid operand");
    expectAt(4, 1'b0, 1'b1, "R3 last cycle edge");
    expectAt(5, 1'b1, 1'b0, "R3 granted after operand");
    repeat (3) step();
    cpuLastCycle = 1'b1;
    step();
    cpuBusy = 1'b0; cpuLastCycle = 1'b0;
    step();
    releaseBus(4);

    // R4: locked sequence holds off the grant
    cpuLocked = 1'b1; extReq = 1'b1;
    expectAt(3, 1'b0, 1'b1, "R4 locked");
    expectAt(6, 1'b0, 1'b1, "R4 still locked");
    expectAt(7, 1'b1, 1'b0, "R4 granted after unlock");
    repeat (6) step();
    cpuLocked = 1'b0;
    step();
    releaseBus(4);

    // R5: grant in the gap between two operands
    cpuBusy = 1'b1; cpuLastCycle = 1'b0; cpuBoundary = 1'b0; extReq = 1'b1;
    expectAt(2, 1'b0, 1'b1, "R5 inside operand");
    expectAt(3, 1'b1, 1'b0, "R5 granted at operand gap");
    step();
    cpuLastCycle = 1'b1;
    step();
    cpuBusy = 1'b0; cpuLastCycle = 1'b0; cpuBoundary = 1'b1;
    step();
    releaseBus(4);

    // R5: idle but not at a boundary
    cpuBoundary = 1'b0; extReq = 1'b1;
    expectAt(5, 1'b0, 1'b1, "R5 boundary low");
    expectAt(6, 1'b1, 1'b0, "R5 granted at boundary");
    repeat (5) step();
    cpuBoundary = 1'b1;
    step();
    releaseBus(4);

    // R9 / R6: request withdrawn for one clock, then back
    extReq = 1'b1;
    expectAt(3, 1'b1, 1'b0, "R6 first grant");
    repeat (3) step();
    extReq = 1'b0;
    expectAt(3, 1'b0, 1'b1, "R9 withdrawn request");
    expectAt(4, 1'b0, 1'b1, "R6 minimum low");
    expectAt(5, 1'b1, 1'b0, "R6 regrant");
    step();
    extReq = 1'b1;
    repeat (4) step();
    releaseBus(7);

    repeat (3) step();
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 pending expectations: %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: cycle %0d expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule